// File: doc/BRIEF.md
# Two-Channel Voice Loopback and Swap Router

This block routes 8-bit voice samples between a serial-bus side and a two-line converter side, one sample per channel per frame. Each frame it takes two downstream bus samples and two converter samples. It produces two upstream bus samples and two converter-bound samples. A 3-bit mode value picks one of several fixed cross-connects: normal pass-through, loopback of either channel or of both, a duplex cross loop, and a channel swap.

Software writes the mode through a one-cycle write port and can always read back the stored value. The routing is combinational. Its results are captured into the output registers only on a frame strobe. A mode write therefore changes nothing until the next strobe, and every output frame comes from a single routing.

Top module: `voice_loop_router`

## Requirements
- R1: While reset is asserted, and after it is released, all four sample outputs are zero and the mode readback is 3'b000.
- R2: In the cycle after a write (`wr_en_i` high at a clock edge), `mode_rd_o` equals the written 3-bit value. This holds for every code, including the unused codes 3'b101 and 3'b110.
- R3: On a clock edge where `frame_i` is low, all four sample outputs keep their values.
- R4: On a clock edge where `frame_i` is high, the outputs are routed with the mode held before that edge. A write in the same cycle as the strobe takes effect at the next strobe.
- R5: Mode 3'b000 (normal) sends tx0 to b1_up, tx1 to b2_up, b1_dn to rx0 and b2_dn to rx1.
- R6: Mode 3'b001 (channel 2 loop) sends tx0 to b1_up, b2_dn to b2_up, b1_dn to rx0 and tx1 to rx1.
- R7: Mode 3'b010 (channel 1 loop) sends b1_dn to b1_up, tx1 to b2_up, tx0 to rx0 and b2_dn to rx1.
- R8: Mode 3'b011 (both loop) sends b1_dn to b1_up, b2_dn to b2_up, tx0 to rx0 and tx1 to rx1.
- R9: Mode 3'b100 (duplex cross loop) sends b2_dn to b1_up, b1_dn to b2_up, tx1 to rx0 and tx0 to rx1.
- R10: Mode 3'b111 (swap) sends tx1 to b1_up, tx0 to b2_up, b2_dn to rx0 and b1_dn to rx1.
- R11: The unused codes 3'b101 and 3'b110 route exactly like mode 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Mode write strobe |
| wr_data_i | input | 3 | Mode value to write |
| mode_rd_o | output | 3 | Stored mode readback |
| frame_i | input | 1 | Frame strobe; outputs load on it |
| b1_dn_i | input | 8 | Downstream bus sample, channel 1 |
| b2_dn_i | input | 8 | Downstream bus sample, channel 2 |
| tx0_i | input | 8 | Converter sample, line 0 |
| tx1_i | input | 8 | Converter sample, line 1 |
| b1_up_o | output | 8 | Upstream bus sample, channel 1 |
| b2_up_o | output | 8 | Upstream bus sample, channel 2 |
| rx0_o | output | 8 | Converter-bound sample, line 0 |
| rx1_o | output | 8 | Converter-bound sample, line 1 |

## Verification
The bench walks all eight codes with random samples and random frame strobes. A wrong cross-connect entry shows up as a sample landing on the wrong sink. The bench writes the mode in the same cycle as a strobe: a design that applied the new mode early would route that frame with the new table. Idle cycles between strobes catch outputs that follow the inputs instead of holding. The unused codes are read back to confirm they are stored unchanged, and their frames are compared against normal routing, which catches a design that clamps those codes or routes them by some other table.

// File: rtl/voice_route_pkg.sv
package voice_route_pkg;
  localparam int MODE_W  = 3;
  localparam int N_PORTS = 4;
  localparam int SEL_W   = $clog2(N_PORTS);

  // source index: 0 b1_dn, 1 b2_dn, 2 tx0, 3 tx1
  // sink index:   0 b1_up, 1 b2_up, 2 rx0, 3 rx1
  typedef enum logic [MODE_W-1:0] {
    M_NORMAL = 3'b000,
    M_LOOP2  = 3'b001,
    M_LOOP1  = 3'b010,
    M_LOOP12 = 3'b011,
    M_DUPLEX = 3'b100,
    M_RSV5   = 3'b101,
    M_RSV6   = 3'b110,
    M_SWAP   = 3'b111
  } mode_e;

  typedef logic [N_PORTS-1:0][SEL_W-1:0] sel_map_t;

  // entries listed sink3..sink0
  function automatic sel_map_t mode_map(input logic [MODE_W-1:0] m);
    case (m)
      M_LOOP2:  return {2'd3, 2'd0, 2'd1, 2'd2};
      M_LOOP1:  return {2'd1, 2'd2, 2'd3, 2'd0};
      M_LOOP12: return {2'd3, 2'd2, 2'd1, 2'd0};
      M_DUPLEX: return {2'd2, 2'd3, 2'd0, 2'd1};
      M_SWAP:   return {2'd0, 2'd1, 2'd2, 2'd3};
      default:  return {2'd1, 2'd0, 2'd3, 2'd2}; // normal and unused codes
    endcase
  endfunction
endpackage

// File: rtl/vr_mode_reg.sv
module vr_mode_reg
  import voice_route_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [MODE_W-1:0] wr_data_i,
  output logic [MODE_W-1:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_o <= M_NORMAL;
    else if (wr_en_i) mode_o <= wr_data_i;
  end

  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mode_o == $past(wr_data_i));
endmodule

// File: rtl/vr_xconnect.sv
module vr_xconnect
  import voice_route_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic [MODE_W-1:0]                mode_i,
  input  logic [N_PORTS-1:0][SAMPLE_W-1:0] src_i,
  output logic [N_PORTS-1:0][SAMPLE_W-1:0] snk_o
);
  sel_map_t sel;
  assign sel = mode_map(mode_i);

  for (genvar k = 0; k < N_PORTS; k++) begin : g_sink
    assign snk_o[k] = src_i[sel[k]];
  end
endmodule

// File: rtl/vr_frame_reg.sv
module vr_frame_reg
  import voice_route_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             frame_i,
  input  logic [N_PORTS-1:0][SAMPLE_W-1:0] d_i,
  output logic [N_PORTS-1:0][SAMPLE_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (frame_i) q_o <= d_i;
  end

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(q_o));
endmodule

// File: rtl/voice_loop_router.sv
module voice_loop_router
  import voice_route_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [MODE_W-1:0]   wr_data_i,
  output logic [MODE_W-1:0]   mode_rd_o,
  input  logic                frame_i,
  input  logic [SAMPLE_W-1:0] b1_dn_i,
  input  logic [SAMPLE_W-1:0] b2_dn_i,
  input  logic [SAMPLE_W-1:0] tx0_i,
  input  logic [SAMPLE_W-1:0] tx1_i,
  output logic [SAMPLE_W-1:0] b1_up_o,
  output logic [SAMPLE_W-1:0] b2_up_o,
  output logic [SAMPLE_W-1:0] rx0_o,
  output logic [SAMPLE_W-1:0] rx1_o
);
  logic [MODE_W-1:0]                mode_q;
  logic [N_PORTS-1:0][SAMPLE_W-1:0] src, routed, out_q;

  assign src = {tx1_i, tx0_i, b2_dn_i, b1_dn_i};

  vr_mode_reg i_mode (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .mode_o(mode_q)
  );

  vr_xconnect #(.SAMPLE_W(SAMPLE_W)) i_xc (
    .mode_i(mode_q), .src_i(src), .snk_o(routed)
  );

  vr_frame_reg #(.SAMPLE_W(SAMPLE_W)) i_out (
    .clk_i, .rst_ni, .frame_i, .d_i(routed), .q_o(out_q)
  );

  assign mode_rd_o = mode_q;
  assign b1_up_o   = out_q[0];
  assign b2_up_o   = out_q[1];
  assign rx0_o     = out_q[2];
  assign rx1_o     = out_q[3];

  // R5, R11: normal and unused codes
  a_r5_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && mode_rd_o inside {3'b000, 3'b101, 3'b110} |=>
      b1_up_o == $past(tx0_i) && b2_up_o == $past(tx1_i) &&
      rx0_o == $past(b1_dn_i) && rx1_o == $past(b2_dn_i));
  a_r6_loop2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && mode_rd_o == 3'b001 |=>
      b2_up_o == $past(b2_dn_i) && rx1_o == $past(tx1_i));
  a_r7_loop1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && mode_rd_o == 3'b010 |=>
      b1_up_o == $past(b1_dn_i) && rx0_o == $past(tx0_i));
  a_r9_duplex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && mode_rd_o == 3'b100 |=>
      b1_up_o == $past(b2_dn_i) && b2_up_o == $past(b1_dn_i) &&
      rx0_o == $past(tx1_i) && rx1_o == $past(tx0_i));
  a_r10_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && mode_rd_o == 3'b111 |=>
      b1_up_o == $past(tx1_i) && b2_up_o == $past(tx0_i) &&
      rx0_o == $past(b2_dn_i) && rx1_o == $past(b1_dn_i));
endmodule

// File: tb/test_voice_loop_router.sv
module test_voice_loop_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_data = '0;
  logic       frame = 1'b0;
  logic [7:0] b1_dn = '0, b2_dn = '0, tx0 = '0, tx1 = '0;
  logic [2:0] mode_rd;
  logic [7:0] b1_up, b2_up, rx0, rx1;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // reference model state
  int         m_mode = 0;
  logic [7:0] e_b1 = 0, e_b2 = 0, e_r0 = 0, e_r1 = 0;
  string      tag = "R1";

  always #2.5 clk = ~clk;

  voice_loop_router i_voice_loop_router (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .mode_rd_o(mode_rd), .frame_i(frame), .b1_dn_i(b1_dn), .b2_dn_i(b2_dn),
    .tx0_i(tx0), .tx1_i(tx1), .b1_up_o(b1_up), .b2_up_o(b2_up),
    .rx0_o(rx0), .rx1_o(rx1)
  );

  function automatic string mode_tag(int m);
    case (m)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      7: return "R10";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; e_b1 = 0; e_b2 = 0; e_r0 = 0; e_r1 = 0; tag = "R1";
    end else begin
      if (frame) begin
        tag = mode_tag(m_mode);
        case (m_mode)
          1: begin e_b1 = tx0;   e_b2 = b2_dn; e_r0 = b1_dn; e_r1 = tx1;   end
          2: begin e_b1 = b1_dn; e_b2 = tx1;   e_r0 = tx0;   e_r1 = b2_dn; end
          3: begin e_b1 = b1_dn; e_b2 = b2_dn; e_r0 = tx0;   e_r1 = tx1;   end
          4: begin e_b1 = b2_dn; e_b2 = b1_dn; e_r0 = tx1;   e_r1 = tx0;   end
          7: begin e_b1 = tx1;   e_b2 = tx0;   e_r0 = b2_dn; e_r1 = b1_dn; end
          default: begin e_b1 = tx0; e_b2 = tx1; e_r0 = b1_dn; e_r1 = b2_dn; end
        endcase
      end else begin
        tag = "R3";
      end
      if (wr_en) m_mode = int'(wr_data);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare every clock, away from the edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
    check(tag, "b1_up", int'(b1_up), int'(e_b1));
    check(tag, "b2_up", int'(b2_up), int'(e_b2));
    check(tag, "rx0", int'(rx0), int'(e_r0));
    check(tag, "rx1", int'(rx1), int'(e_r1));
    check(rst_n ? "R2" : "R1", "mode_rd", int'(mode_rd), m_mode);
  end

  task automatic step(bit f, bit w, logic [2:0] d);
    @(negedge clk);
    #1;
    frame = f; wr_en = w; wr_data = d;
    b1_dn = 8'($urandom); b2_dn = 8'($urandom);
    tx0 = 8'($urandom); tx1 = 8'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // every code, random frames
    for (int m = 0; m < 8; m++) begin
      step(1'b0, 1'b1, 3'(m));
      for (int k = 0; k < 40; k++) step(1'($urandom), 1'b0, 3'd0);
      for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 3'd0);
    end
    // R4: write in the strobe cycle, old routing applies to that frame
    step(1'b0, 1'b1, 3'd0);
    step(1'b1, 1'b1, 3'd7);
    step(1'b0, 1'b0, 3'd0);
    @(negedge clk);
    n_tests++;
    if (b1_up !== e_b1 || mode_rd !== 3'd7) begin
      n_fail++;
      $display("FAIL R4 strobe-cycle write: actual %0h expected %0h", b1_up, e_b1);
    end
    step(1'b1, 1'b1, 3'd4);
    for (int k = 0; k < 30; k++) step(1'($urandom), 1'($urandom), 3'($urandom));
    step(1'b0, 1'b0, 3'd0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule